// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block sits beside the command decoder of a 2 MB serial NOR memory built from 32 sectors of 64 KB. For every transaction it decides whether a command that would change stored data may start. It holds three pieces of state:

- the write-enable latch;
- the three block-protect bits;
- the status-lock bit.

The decision is taken in the cycle where the decoder reports that chip select has risen. The block then emits a one-cycle go or reject pulse. Program and erase timing belong to an engine outside this block. That engine reports its progress to the gate with a busy level and a completion strobe.

A modifying command is one of page program, sector erase, bulk erase or status write. It goes ahead only when all of the following hold:

- the enable latch is set;
- the transaction carried a whole number of bytes of clock pulses;
- its target is outside the protected top-of-array region;
- for a status write, the hardware lock is not active.

Reads and other opcodes pass through untouched, and the gate produces no verdict for them.

Top module: `flash_wp_gate`

## Requirements
- R1: After reset the write-enable latch, block-protect bits and status-lock bit are all zero, and neither verdict pulse is active.
- R2: Opcode 06h sets the write-enable latch (status bit 1), and opcode 04h clears it. Both take effect one cycle after the chip-select-rise cycle, and neither produces a go or reject pulse.
- R3: A modifying command (02h program, D8h sector erase, C7h bulk erase, 01h status write) is rejected while the write-enable latch is clear.
- R4: A modifying command whose clock count has nonzero low three bits is rejected, and the write-enable latch keeps its value.
- R5: Program and sector erase are rejected when address bits [20:16] name a protected sector. Protect code 0 locks nothing. Codes 1 to 5 lock the top 1, 2, 4, 8 or 16 sectors respectively. Codes 6 and 7 lock all 32 sectors.
- R6: Bulk erase is rejected whenever any block-protect bit is set.
- R7: A status write is rejected when the status-lock bit is 1 and the write-protect pin is low. It is accepted when that pin is high.
- R8: An accepted status write loads the status-lock bit from data bit 7 and the protect bits from data bits 4:2. Both are visible one cycle after the decision.
- R9: The completion strobe clears the write-enable latch. A rejected command leaves the latch unchanged.
- R10: The status output carries the status-lock bit at bit 7, the protect bits at bits 4:2, the enable latch at bit 1, and the busy input at bit 0. Bits 6:5 read 0.
- R11: Go and reject are registered single-cycle pulses, due one cycle after the chip-select-rise cycle, and never both high. Any opcode outside the six listed produces neither pulse.
- R12: When opcode 06h is decided in the same cycle as a completion strobe, the write-enable latch ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_rise | input | 1 | One-cycle strobe: chip select rose, decide now |
| opcode | input | 8 | Command byte of the finished transaction |
| addr | input | 21 | Byte address of the transaction |
| clk_count | input | 16 | Serial clock pulses counted while selected |
| sr_data | input | 8 | Data byte carried by a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Engine busy level, reported as status bit 0 |
| done_strobe | input | 1 | Engine finished an accepted modifying command |
| exec_go | output | 1 | Pulse: command may execute |
| exec_reject | output | 1 | Pulse: command is refused |
| status | output | 8 | Status register value |

## Verification
The go and reject pulses, and every change to status bits 7, 4:2 and 1, come from registers. They are due on the clock edge that samples the chip-select-rise or completion strobe. Status bit 0 follows the busy input in the same cycle with no register.

The bench drives inputs and reads outputs one time unit after each rising edge. At each edge it steps a behavioural model with the inputs held across that edge, and then compares every output with the model. The directed checks read the verdict pulses in the cycle right after the decision, and read the status after the following idle cycle.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    localparam int ADDR_W    = 21;
    localparam int SECT_W    = 5;
    localparam int CNT_W     = 16;
    localparam int BP_W      = 3;
    localparam int BYTE_BITS = 3;

    typedef enum logic [7:0] {
        OP_WREN = 8'h06,
        OP_WRDI = 8'h04,
        OP_WRSR = 8'h01,
        OP_PP   = 8'h02,
        OP_SE   = 8'hD8,
        OP_BE   = 8'hC7
    } flash_op_e;

    typedef struct packed {
        logic is_wren;
        logic is_wrdi;
        logic is_wrsr;
        logic is_pp;
        logic is_se;
        logic is_be;
    } cmd_kind_t;

    typedef struct packed {
        logic go;
        logic rej;
    } verdict_t;

    // Protected span grows from the top of the array: code n locks 2^(n-1) sectors.
    function automatic logic sector_locked(input logic [BP_W-1:0] bp,
                                           input int sect,
                                           input int sect_bits);
        int span;
        if (bp == '0) return 1'b0;
        if (int'(bp) - 1 >= sect_bits) return 1'b1;
        span = 1 << (int'(bp) - 1);
        return sect >= ((1 << sect_bits) - span);
    endfunction

endpackage

// File: rtl/wp_cmd_classify.sv
module wp_cmd_classify
    import flash_wp_pkg::*;
(
    input  logic [7:0] opcode,
    output cmd_kind_t  kind
);
    always_comb begin
        kind         = '0;
        kind.is_wren = (opcode == OP_WREN);
        kind.is_wrdi = (opcode == OP_WRDI);
        kind.is_wrsr = (opcode == OP_WRSR);
        kind.is_pp   = (opcode == OP_PP);
        kind.is_se   = (opcode == OP_SE);
        kind.is_be   = (opcode == OP_BE);
    end
endmodule

// File: rtl/wp_region_check.sv
module wp_region_check
    import flash_wp_pkg::*;
#(
    parameter int S_W = SECT_W
) (
    input  logic [BP_W-1:0] bp,
    input  logic [S_W-1:0]  sect,
    output logic            locked
);
    localparam int NSECT = 1 << S_W;

    logic [NSECT-1:0] lock_map;

    for (genvar g = 0; g < NSECT; g++) begin : g_sect
        assign lock_map[g] = sector_locked(bp, g, S_W);
    end

    assign locked = lock_map[sect];
endmodule

// File: rtl/wp_state_regs.sv
module wp_state_regs
    import flash_wp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            set_wel,
    input  logic            clr_wel,
    input  logic            load_sr,
    input  logic [7:0]      sr_data,
    input  logic            wp_n,
    output logic            wel,
    output logic [BP_W-1:0] bp,
    output logic            srwd
);
    logic unused_sr_bits;
    assign unused_sr_bits = ^{sr_data[6:5], sr_data[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            wel  <= 1'b0;
            bp   <= '0;
            srwd <= 1'b0;
        end else begin
            if (set_wel)      wel <= 1'b1;
            else if (clr_wel) wel <= 1'b0;
            if (load_sr) begin
                srwd <= sr_data[7];
                bp   <= sr_data[4:2];
            end
        end
    end

    // R7
    sr_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (srwd && !wp_n) |=> ($stable(bp) && $stable(srwd)));
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
    import flash_wp_pkg::*;
#(
    parameter int A_W = ADDR_W,
    parameter int S_W = SECT_W,
    parameter int C_W = CNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_rise,
    input  logic [7:0]     opcode,
    input  logic [A_W-1:0] addr,
    input  logic [C_W-1:0] clk_count,
    input  logic [7:0]     sr_data,
    input  logic           wp_n,
    input  logic           busy,
    input  logic           done_strobe,
    output logic           exec_go,
    output logic           exec_reject,
    output logic [7:0]     status
);
    localparam int SECT_LSB = A_W - S_W;

    cmd_kind_t       kind;
    logic            locked;
    logic            wel;
    logic [BP_W-1:0] bp;
    logic            srwd;
    logic            is_mod;
    logic            whole_bytes;
    logic            target_ok;
    logic            allow;
    logic            set_wel;
    logic            clr_wel;
    logic            load_sr;
    verdict_t        verdict_d;
    verdict_t        verdict_q;

    logic unused_low_bits;
    assign unused_low_bits = ^{addr[SECT_LSB-1:0], clk_count[C_W-1:BYTE_BITS]};

    wp_cmd_classify u_classify (
        .opcode (opcode),
        .kind   (kind)
    );

    wp_region_check #(.S_W(S_W)) u_region (
        .bp     (bp),
        .sect   (addr[A_W-1 -: S_W]),
        .locked (locked)
    );

    wp_state_regs u_state (
        .clk     (clk),
        .rst     (rst),
        .set_wel (set_wel),
        .clr_wel (clr_wel),
        .load_sr (load_sr),
        .sr_data (sr_data),
        .wp_n    (wp_n),
        .wel     (wel),
        .bp      (bp),
        .srwd    (srwd)
    );

    always_comb begin
        is_mod      = kind.is_pp | kind.is_se | kind.is_be | kind.is_wrsr;
        whole_bytes = (clk_count[BYTE_BITS-1:0] == '0);
        target_ok   = 1'b1;
        if (kind.is_pp || kind.is_se) target_ok = !locked;
        if (kind.is_be)               target_ok = (bp == '0);
        if (kind.is_wrsr)             target_ok = !(srwd && !wp_n);
        allow       = wel && whole_bytes && target_ok;

        verdict_d.go  = cs_rise && is_mod && allow;
        verdict_d.rej = cs_rise && is_mod && !allow;

        set_wel = cs_rise && kind.is_wren;
        clr_wel = (cs_rise && kind.is_wrdi) || done_strobe;
        load_sr = verdict_d.go && kind.is_wrsr;
    end

    always_ff @(posedge clk) begin
        if (rst) verdict_q <= '0;
        else     verdict_q <= verdict_d;
    end

    assign exec_go     = verdict_q.go;
    assign exec_reject = verdict_q.rej;
    assign status      = {srwd, 2'b00, bp, wel, busy};

    // R11
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(exec_go && exec_reject));

    // R11
    verdict_src_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_go || exec_reject) |-> $past(cs_rise));

    // R3
    go_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
        exec_go |-> $past(status[1]));

    // R4
    go_count_chk: assert property (@(posedge clk) disable iff (rst)
        exec_go |-> ($past(clk_count[BYTE_BITS-1:0]) == '0));

    // R6
    be_bp_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_go && ($past(opcode) == OP_BE)) |-> ($past(status[4:2]) == '0));

    // R2
    wel_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[1]) |-> $past(cs_rise && (opcode == OP_WREN)));

    // R9
    wel_done_chk: assert property (@(posedge clk) disable iff (rst)
        (done_strobe && !(cs_rise && (opcode == OP_WREN))) |=> !status[1]);
endmodule

// File: tb/flash_wp_gate_test.sv
module flash_wp_gate_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_rise = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [20:0] addr = '0;
    logic [15:0] clk_count = '0;
    logic [7:0]  sr_data = '0;
    logic        wp_n = 1'b1;
    logic        busy = 1'b0;
    logic        done_strobe = 1'b0;
    logic        exec_go;
    logic        exec_reject;
    logic [7:0]  status;

    int total = 0;
    int fails = 0;

    // behavioural model state
    bit m_wel, m_srwd, m_go, m_rej;
    int m_bp;
    bit got_go, got_rej;

    flash_wp_gate uut (
        .clk(clk), .rst(rst), .cs_rise(cs_rise), .opcode(opcode), .addr(addr),
        .clk_count(clk_count), .sr_data(sr_data), .wp_n(wp_n), .busy(busy),
        .done_strobe(done_strobe), .exec_go(exec_go), .exec_reject(exec_reject),
        .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit in_prot(int bp, int a);
        case (bp)
            0: return 0;
            1: return a >= 32'h1F0000;
            2: return a >= 32'h1E0000;
            3: return a >= 32'h1C0000;
            4: return a >= 32'h180000;
            5: return a >= 32'h100000;
            default: return 1;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit ok;
        m_go = 0; m_rej = 0;
        if (rst) begin
            m_wel = 0; m_srwd = 0; m_bp = 0;
        end else begin
            if (done_strobe) m_wel = 0;
            if (cs_rise) begin
                case (opcode)
                    8'h06: m_wel = 1;
                    8'h04: m_wel = 0;
                    8'h02, 8'hD8, 8'hC7, 8'h01: begin
                        ok = m_wel && (clk_count % 8 == 0);
                        if (opcode == 8'h02 || opcode == 8'hD8) ok = ok && !in_prot(m_bp, int'(addr));
                        if (opcode == 8'hC7) ok = ok && (m_bp == 0);
                        if (opcode == 8'h01) ok = ok && !(m_srwd && !wp_n);
                        m_go = ok; m_rej = !ok;
                        if (ok && opcode == 8'h01) begin
                            m_srwd = sr_data[7];
                            m_bp   = int'(sr_data[4:2]);
                        end
                    end
                    default: ;
                endcase
            end
        end
    endtask

    task automatic tick();
        int exp_st;
        @(posedge clk);
        model_step();
        #1;
        exp_st = (int'(m_srwd) << 7) | (m_bp << 2) | (int'(m_wel) << 1) | int'(busy);
        check("R10/R11 go", int'(exec_go), int'(m_go));
        check("R10/R11 reject", int'(exec_reject), int'(m_rej));
        check("R10/R11 status", int'(status), exp_st);
    endtask

    task automatic send(logic [7:0] op, int a, int cnt, logic [7:0] d);
        opcode = op; addr = a[20:0]; clk_count = cnt[15:0]; sr_data = d;
        cs_rise = 1'b1;
        tick();
        got_go = exec_go; got_rej = exec_reject;
        cs_rise = 1'b0;
        tick();
    endtask

    task automatic finish_cmd();
        done_strobe = 1'b1;
        tick();
        done_strobe = 1'b0;
        tick();
    endtask

    task automatic set_protect(logic [7:0] d);
        send(8'h06, 0, 8, 8'h00);
        send(8'h01, 0, 16, d);
        finish_cmd();
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1
        check("R1 status", int'(status), 0);
        check("R1 verdict", int'({exec_go, exec_reject}), 0);

        // R3
        send(8'h01, 0, 16, 8'h1C);
        check("R3 wrsr without latch", int'({got_go, got_rej}), 1);
        send(8'h02, 0, 40, 8'h00);
        check("R3 program without latch", int'({got_go, got_rej}), 1);

        // R2
        send(8'h06, 0, 8, 8'h00);
        check("R2 wren sets", int'(status[1]), 1);
        check("R2 wren no verdict", int'({got_go, got_rej}), 0);
        send(8'h04, 0, 8, 8'h00);
        check("R2 wrdi clears", int'(status[1]), 0);

        // R4
        send(8'h06, 0, 8, 8'h00);
        send(8'h02, 32'h001000, 13, 8'h00);
        check("R4 odd count rejected", int'({got_go, got_rej}), 1);
        check("R9 latch kept after reject", int'(status[1]), 1);

        // R5 / R9
        send(8'h02, 32'h1FFFFF, 32, 8'h00);
        check("R5 no protection", int'({got_go, got_rej}), 2);
        check("R9 latch held until done", int'(status[1]), 1);
        finish_cmd();
        check("R9 done clears latch", int'(status[1]), 0);

        // R8
        set_protect(8'h04);
        check("R8 bp loaded", int'(status[4:2]), 1);

        // R5 sector 31 boundary
        send(8'h06, 0, 8, 8'h00);
        send(8'h02, 32'h1F0000, 16, 8'h00);
        check("R5 sector 31 locked", int'({got_go, got_rej}), 1);
        send(8'h02, 32'h1EFFFF, 16, 8'h00);
        check("R5 sector 30 open", int'({got_go, got_rej}), 2);
        finish_cmd();

        // R5 every code, boundaries
        for (int b = 2; b < 8; b++) begin
            set_protect(8'(b << 2));
            for (int s = 0; s < 32; s += 3) begin
                send(8'h06, 0, 8, 8'h00);
                send(8'hD8, s << 16, 32, 8'h00);
                check("R5 sector erase", int'(got_go), int'(!in_prot(b, s << 16)));
                if (got_go) finish_cmd();
                else send(8'h04, 0, 8, 8'h00);
            end
        end

        // R6
        set_protect(8'h08);
        send(8'h06, 0, 8, 8'h00);
        send(8'hC7, 0, 8, 8'h00);
        check("R6 bulk erase blocked", int'({got_go, got_rej}), 1);
        set_protect(8'h00);
        send(8'h06, 0, 8, 8'h00);
        send(8'hC7, 0, 8, 8'h00);
        check("R6 bulk erase allowed", int'({got_go, got_rej}), 2);
        finish_cmd();

        // R7
        set_protect(8'h8C);
        check("R8 lock bit loaded", int'(status), 8'h8C);
        wp_n = 1'b0;
        tick();
        send(8'h06, 0, 8, 8'h00);
        send(8'h01, 0, 16, 8'h00);
        check("R7 hardware lock rejects", int'({got_go, got_rej}), 1);
        check("R7 status unchanged", int'(status), 8'h8E);
        wp_n = 1'b1;
        tick();
        send(8'h01, 0, 16, 8'h00);
        check("R7 pin high accepts", int'({got_go, got_rej}), 2);
        finish_cmd();
        check("R8 cleared", int'(status), 0);

        // R11
        send(8'h03, 0, 32, 8'h00);
        check("R11 read opcode no verdict", int'({got_go, got_rej}), 0);

        // R12
        opcode = 8'h06; cs_rise = 1'b1; done_strobe = 1'b1;
        tick();
        cs_rise = 1'b0; done_strobe = 1'b0;
        tick();
        check("R12 set wins over done", int'(status[1]), 1);

        // R10
        busy = 1'b1;
        #1;
        check("R10 busy bit", int'(status[0]), 1);
        tick();
        busy = 1'b0;
        tick();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule